// File: doc/BRIEF.md
# Two-Channel Indirect Register Port

This block is the byte-wide host-side front end of a dual serial controller. A small address window holds four byte ports: a control port and a data port for each of two channels. The window is spread over the bus by a configurable stride. Most of a channel's configuration sits behind its control port. Software first writes an index to that port. The next control access then reaches the register the index names, and the index drops back to zero afterwards.

Data-port accesses bypass the index. A write loads the channel's transmit holding byte, and a read returns the byte the receive path presents. Writes to the two time-constant registers also land in a read-back mirror. A command field in the master register can clear either channel or both. Every stored register write raises a one-cycle strobe for that channel and index, so the serial paths can act on new settings.

Top module: `dual_chan_ptr_if`

## Requirements
- R1: The port select is byte-address bit SHIFT, where 0 is the control port and 1 is the data port. The channel select is bit SHIFT+1. Index 0, at the lower addresses, is channel B. Index 1 is channel A. The window covers 4 << SHIFT bytes, and bits below SHIFT are not brought into the block.
- R2: A control write while the channel's index is 0 stores the byte in register 0, and loads the index from the byte's bits [3:0].
- R3: A control write while the index is non-zero stores the byte in the register the index names. The index then returns to 0. A control read while the index is non-zero also returns the index to 0.
- R4: Only bits [7:0] of the write data are used.
- R5: A data-port write loads the channel's transmit holding byte. A data-port read returns that channel's receive byte input. Neither changes the index.
- R6: Writes to register 12 (time constant low) and register 13 (time constant high) update both the stored copy and a mirror. A control read with the index at 12 or 13 returns the mirror.
- R7: A control read with the index at 0 returns the channel's status input. With any other index except 12 and 13, it returns 0x00.
- R8: A stored register write raises reg_wr_stb[channel][index] for exactly the following cycle. At most one strobe is high at a time.
- R9: A control write to register 9 with bits [7:6] non-zero is a command, not a store. 01 clears channel B (index 0), 10 clears channel A (index 1), and 11 clears both. The command works from either channel. A cleared channel has its registers, mirror, transmit byte and index set to 0, and the other channel is untouched. The value 00 stores normally.
- R10: bus_rdata is registered. It shows the read result in the cycle after bus_rd, and holds its value otherwise.
- R11: When bus_rd and bus_wr are both high, the write is performed and the read is dropped. bus_rdata keeps its value, and the read has no effect on the index.
- R12: The synchronous reset clears all registers, mirrors, transmit bytes, indices, strobes and bus_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W-SHIFT | Byte address bits [ADDR_W-1:SHIFT] |
| bus_wdata | input | BUS_W | Write data, low byte used |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| ch_status | input | 2x8 | Status byte per channel |
| rx_byte | input | 2x8 | Receive holding byte per channel |
| bus_rdata | output | 8 | Registered read data |
| tx_byte | output | 2x8 | Transmit holding byte per channel |
| reg_wr_stb | output | 2x2^PTR_W | One-cycle register write strobes |
| cfg_regs | output | 2x2^PTR_W x8 | Stored register copies per channel |

## Verification
Only one bus access can occur per cycle. Even so, two functions can meet in a single cycle. The first case is a read and a write strobe raised together. The bench provokes this both at random and directly, while a register index is pending. It judges the result by requiring an unchanged bus_rdata, and by requiring that the index has not been consumed by the dropped read. The second case is a clear command issued from one channel while the other channel holds a non-zero index. The bench judges this by the cleared registers and transmit byte, and by the next control read of the cleared channel landing on its status register.

// File: rtl/cptr_pkg.sv
package cptr_pkg;

    localparam int PTR_W_DEF  = 4;
    localparam int REG_STAT   = 0;
    localparam int REG_MCMD   = 9;
    localparam int REG_TC_LO  = 12;
    localparam int REG_TC_HI  = 13;

    typedef enum logic [1:0] {
        CMD_NONE     = 2'b00,
        CMD_CLR_B    = 2'b01,
        CMD_CLR_A    = 2'b10,
        CMD_CLR_BOTH = 2'b11
    } mcmd_e;

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic       chan;
        logic       is_data;
        logic [7:0] wbyte;
    } bus_op_t;

    // Per-channel clear mask requested by a command byte; bit i clears channel i.
    function automatic logic [1:0] clear_mask(input logic [7:0] b);
        mcmd_e c;
        c = mcmd_e'(b[7:6]);
        case (c)
            CMD_CLR_B:    return 2'b01;
            CMD_CLR_A:    return 2'b10;
            CMD_CLR_BOTH: return 2'b11;
            default:      return 2'b00;
        endcase
    endfunction

endpackage

// File: rtl/cptr_addr_dec.sv
module cptr_addr_dec
    import cptr_pkg::*;
#(
    parameter int SHIFT  = 1,
    parameter int ADDR_W = SHIFT + 2,
    parameter int BUS_W  = 8
) (
    input  logic [ADDR_W-1:SHIFT] bus_addr,
    input  logic [BUS_W-1:0]      bus_wdata,
    input  logic                  bus_rd,
    input  logic                  bus_wr,
    output bus_op_t               op
);

    always_comb begin
        op.is_data = bus_addr[SHIFT];
        op.chan    = bus_addr[SHIFT+1];
        op.wr      = bus_wr;
        op.rd      = bus_rd & ~bus_wr;   // write wins a collision
        op.wbyte   = bus_wdata[7:0];
    end

endmodule

// File: rtl/cptr_chan_regs.sv
module cptr_chan_regs
    import cptr_pkg::*;
#(
    parameter int PTR_W  = PTR_W_DEF,
    parameter bit CH_IDX = 1'b0,
    localparam int NREG  = 1 << PTR_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      clr,
    input  bus_op_t                   op,
    input  logic [7:0]                stat_in,
    input  logic [7:0]                rx_in,
    output logic [7:0]                rd_byte,
    output logic [NREG-1:0][7:0]      cfg_q,
    output logic [NREG-1:0]           wr_stb,
    output logic [7:0]                tx_hold,
    output logic [1:0]                cmd_req
);

    logic [PTR_W-1:0] ptr;
    logic [7:0]       mir_lo, mir_hi;
    logic             sel, ctrl_wr, ctrl_rd, data_wr, is_cmd;

    assign sel     = (op.chan == CH_IDX);
    assign ctrl_wr = sel & op.wr & ~op.is_data;
    assign ctrl_rd = sel & op.rd & ~op.is_data;
    assign data_wr = sel & op.wr &  op.is_data;
    assign is_cmd  = ctrl_wr && (ptr == PTR_W'(REG_MCMD)) && (clear_mask(op.wbyte) != 2'b00);
    assign cmd_req = is_cmd ? clear_mask(op.wbyte) : 2'b00;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr     <= '0;
            cfg_q   <= '0;
            wr_stb  <= '0;
            tx_hold <= '0;
            mir_lo  <= '0;
            mir_hi  <= '0;
        end else begin
            wr_stb <= '0;
            if (data_wr)
                tx_hold <= op.wbyte;
            if (ctrl_wr) begin
                if (ptr == '0) begin
                    cfg_q[REG_STAT] <= op.wbyte;
                    wr_stb[REG_STAT] <= 1'b1;
                    ptr <= op.wbyte[PTR_W-1:0];
                end else begin
                    ptr <= '0;
                    if (!is_cmd) begin
                        cfg_q[ptr]  <= op.wbyte;
                        wr_stb[ptr] <= 1'b1;
                        if (ptr == PTR_W'(REG_TC_LO)) mir_lo <= op.wbyte;
                        if (ptr == PTR_W'(REG_TC_HI)) mir_hi <= op.wbyte;
                    end
                end
            end
            if (ctrl_rd && ptr != '0)
                ptr <= '0;
        end
    end

    always_comb begin
        if (op.is_data)
            rd_byte = rx_in;
        else if (ptr == PTR_W'(REG_STAT))
            rd_byte = stat_in;
        else if (ptr == PTR_W'(REG_TC_LO))
            rd_byte = mir_lo;
        else if (ptr == PTR_W'(REG_TC_HI))
            rd_byte = mir_hi;
        else
            rd_byte = 8'h00;
    end

    // R3: a register access consumes the index
    assert_ptr_home_R3: assert property (@(posedge clk) disable iff (rst)
        (sel && !op.is_data && (op.rd || op.wr) && ptr != '0) |=> (ptr == '0));

    // R5: data-port traffic leaves the index alone
    assert_data_keeps_ptr_R5: assert property (@(posedge clk) disable iff (rst)
        (sel && op.is_data && (op.rd || op.wr) && !clr) |=> $stable(ptr));

    // R6: time-constant low write reaches the mirror
    assert_mirror_lo_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && ptr == PTR_W'(REG_TC_LO) && !clr) |=> (mir_lo == $past(op.wbyte)));

    // R9: a clear leaves the channel idle
    assert_clear_state_R9: assert property (@(posedge clk) disable iff (rst)
        clr |=> (ptr == '0 && tx_hold == 8'h00 && mir_lo == 8'h00 && mir_hi == 8'h00));

endmodule

// File: rtl/dual_chan_ptr_if.sv
module dual_chan_ptr_if
    import cptr_pkg::*;
#(
    parameter int SHIFT  = 1,
    parameter int ADDR_W = SHIFT + 2,
    parameter int BUS_W  = 8,
    parameter int PTR_W  = PTR_W_DEF,
    localparam int NREG  = 1 << PTR_W
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [ADDR_W-1:SHIFT]         bus_addr,
    input  logic [BUS_W-1:0]              bus_wdata,
    input  logic                          bus_rd,
    input  logic                          bus_wr,
    input  logic [1:0][7:0]               ch_status,
    input  logic [1:0][7:0]               rx_byte,
    output logic [7:0]                    bus_rdata,
    output logic [1:0][7:0]               tx_byte,
    output logic [1:0][NREG-1:0]          reg_wr_stb,
    output logic [1:0][NREG-1:0][7:0]     cfg_regs
);

    bus_op_t         op;
    logic [1:0][7:0] rd_byte_w;
    logic [1:0][1:0] cmd_req_w;
    logic [1:0]      clr;

    cptr_addr_dec #(.SHIFT(SHIFT), .ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_dec (
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .op        (op)
    );

    for (genvar c = 0; c < 2; c++) begin : g_ch
        cptr_chan_regs #(.PTR_W(PTR_W), .CH_IDX(1'(c))) u_chan (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr[c]),
            .op      (op),
            .stat_in (ch_status[c]),
            .rx_in   (rx_byte[c]),
            .rd_byte (rd_byte_w[c]),
            .cfg_q   (cfg_regs[c]),
            .wr_stb  (reg_wr_stb[c]),
            .tx_hold (tx_byte[c]),
            .cmd_req (cmd_req_w[c])
        );
    end

    always_comb begin
        for (int c = 0; c < 2; c++)
            clr[c] = cmd_req_w[0][c] | cmd_req_w[1][c];
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= 8'h00;
        else if (op.rd)
            bus_rdata <= rd_byte_w[op.chan];
    end

    // R8: strobes never overlap
    assert_stb_onehot_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(reg_wr_stb));

    // R11: a colliding read is dropped
    assert_rd_drop_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wr) |=> $stable(bus_rdata));

    // R10: read data moves only after a read
    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/tb_dual_chan_ptr_if.sv
module tb_dual_chan_ptr_if;
    localparam int SHIFT  = 1;
    localparam int ADDR_W = 3;
    localparam int BUS_W  = 32;
    localparam int PTR_W  = 4;
    localparam int NREG   = 16;

    logic clk = 1'b0;
    logic rst;
    always #10 clk = ~clk;

    logic [ADDR_W-1:SHIFT]      bus_addr;
    logic [BUS_W-1:0]           bus_wdata;
    logic                       bus_rd, bus_wr;
    logic [1:0][7:0]            ch_status, rx_byte;
    logic [7:0]                 bus_rdata;
    logic [1:0][7:0]            tx_byte;
    logic [1:0][NREG-1:0]       reg_wr_stb;
    logic [1:0][NREG-1:0][7:0]  cfg_regs;

    dual_chan_ptr_if #(.SHIFT(SHIFT), .ADDR_W(ADDR_W), .BUS_W(BUS_W), .PTR_W(PTR_W)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .ch_status(ch_status), .rx_byte(rx_byte),
        .bus_rdata(bus_rdata), .tx_byte(tx_byte), .reg_wr_stb(reg_wr_stb), .cfg_regs(cfg_regs)
    );

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    logic [7:0]           m_cfg [2][NREG];
    logic [7:0]           m_mlo [2];
    logic [7:0]           m_mhi [2];
    logic [7:0]           m_tx  [2];
    int                   m_ptr [2];
    logic [7:0]           m_rd;
    logic [1:0][NREG-1:0] m_stb;

    task automatic chk(input string tag, input string what, input logic [127:0] act, input logic [127:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic void m_clear(input int c);
        for (int i = 0; i < NREG; i++) m_cfg[c][i] = 8'h00;
        m_mlo[c] = 8'h00; m_mhi[c] = 8'h00; m_tx[c] = 8'h00; m_ptr[c] = 0;
    endfunction

    function automatic logic [127:0] m_pack(input int c);
        logic [127:0] v;
        for (int i = 0; i < NREG; i++) v[i*8 +: 8] = m_cfg[c][i];
        return v;
    endfunction

    // One bus cycle: drive at a falling edge, compare at the next falling edge.
    task automatic access(input bit rd, input bit wr, input bit ch, input bit dp, input logic [31:0] d);
        string tag;
        logic [7:0] b;
        int p;
        b = d[7:0];
        ch_status = {8'($urandom), 8'($urandom)};
        rx_byte   = {8'($urandom), 8'($urandom)};
        bus_addr[SHIFT+1] = ch;
        bus_addr[SHIFT]   = dp;
        bus_wdata = d;
        bus_rd = rd;
        bus_wr = wr;
        m_stb = '0;
        tag = "R10";
        if (wr) begin
            if (dp) begin
                m_tx[ch] = b; tag = "R5";
            end else if (m_ptr[ch] == 0) begin
                m_cfg[ch][0] = b; m_stb[ch][0] = 1'b1; m_ptr[ch] = int'(b[3:0]); tag = "R2";
            end else begin
                p = m_ptr[ch];
                m_ptr[ch] = 0;
                if (p == 9 && b[7:6] != 2'b00) begin
                    if (b[6]) m_clear(0);
                    if (b[7]) m_clear(1);
                    tag = "R9";
                end else begin
                    m_cfg[ch][p] = b; m_stb[ch][p] = 1'b1; tag = "R3";
                    if (p == 12) begin m_mlo[ch] = b; tag = "R6"; end
                    if (p == 13) begin m_mhi[ch] = b; tag = "R6"; end
                end
            end
        end
        if (rd && !wr) begin
            if (dp) begin
                m_rd = rx_byte[ch]; tag = "R5";
            end else begin
                case (m_ptr[ch])
                    0:  begin m_rd = ch_status[ch]; tag = "R7"; end
                    12: begin m_rd = m_mlo[ch]; tag = "R6"; end
                    13: begin m_rd = m_mhi[ch]; tag = "R6"; end
                    default: begin m_rd = 8'h00; tag = "R7"; end
                endcase
                m_ptr[ch] = 0;
            end
        end
        if (rd && wr) tag = "R11";
        @(negedge clk);
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        chk(tag, "rdata", 128'(bus_rdata), 128'(m_rd));
        chk("R8", "strobes", 128'(reg_wr_stb), 128'(m_stb));
        for (int c = 0; c < 2; c++) begin
            chk(tag, "cfg", cfg_regs[c], m_pack(c));
            chk(tag, "tx", 128'(tx_byte[c]), 128'(m_tx[c]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual expired expected finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        bus_addr = '0; bus_wdata = '0; bus_rd = 1'b0; bus_wr = 1'b0;
        ch_status = '0; rx_byte = '0;
        m_clear(0); m_clear(1); m_rd = 8'h00; m_stb = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12: reset state
        chk("R12", "rdata after reset", 128'(bus_rdata), 128'h0);
        chk("R12", "strobes after reset", 128'(reg_wr_stb), 128'h0);
        chk("R12", "cfg B after reset", cfg_regs[0], 128'h0);
        chk("R12", "cfg A after reset", cfg_regs[1], 128'h0);
        chk("R12", "tx after reset", 128'(tx_byte), 128'h0);
        access(1, 0, 1, 0, 0);   // index 0 after reset: status read

        // R1: lower data port is channel B, upper is channel A
        access(0, 1, 0, 1, 32'h5A);
        chk("R1", "B data at lower address", 128'(tx_byte[0]), 128'h5A);
        access(0, 1, 1, 1, 32'hC3);
        chk("R1", "A data at upper address", 128'(tx_byte[1]), 128'hC3);
        // R4: upper write-data bits discarded
        access(0, 1, 1, 1, 32'hABCD12F3);
        chk("R4", "masked tx byte", 128'(tx_byte[1]), 128'hF3);

        // Index sequences, mirror readback
        access(0, 1, 0, 0, 12); access(0, 1, 0, 0, 8'h34);
        access(0, 1, 0, 0, 13); access(0, 1, 0, 0, 8'h56);
        access(0, 1, 0, 0, 12); access(1, 0, 0, 0, 0);
        access(0, 1, 0, 0, 13); access(1, 0, 0, 0, 0);
        access(0, 1, 0, 0, 5);  access(1, 0, 0, 0, 0);
        access(1, 0, 0, 0, 0);
        // Data traffic between index write and register access
        access(0, 1, 1, 0, 7);  access(0, 1, 1, 1, 8'h11); access(1, 0, 1, 1, 0);
        access(0, 1, 1, 0, 8'h77);

        // R11: collision while an index is pending
        access(0, 1, 1, 0, 12);
        access(1, 1, 1, 0, 8'h9E);
        access(0, 1, 1, 0, 12); access(1, 0, 1, 0, 0);

        // R9: commands from each channel, with the other mid-sequence
        access(0, 1, 0, 1, 8'h21); access(0, 1, 1, 1, 8'h22);
        access(0, 1, 0, 0, 12);
        access(0, 1, 1, 0, 9);  access(0, 1, 1, 0, 8'h40);
        access(1, 0, 0, 0, 0);
        access(0, 1, 0, 0, 13); access(0, 1, 0, 0, 8'hAA);
        access(0, 1, 0, 0, 9);  access(0, 1, 0, 0, 8'h80);
        access(0, 1, 1, 0, 9);  access(0, 1, 1, 0, 8'h15);
        access(0, 1, 0, 0, 9);  access(0, 1, 0, 0, 8'hC0);

        // Constrained random traffic
        for (int i = 0; i < 800; i++) begin
            int k;
            bit ch;
            logic [31:0] d;
            k  = int'($urandom_range(0, 99));
            ch = 1'($urandom);
            d  = $urandom;
            if (m_ptr[ch] == 9 && ($urandom_range(0, 3) != 0)) d[7:6] = 2'b00;
            if      (k < 20) access(0, 1, ch, 1, d);
            else if (k < 35) access(1, 0, ch, 1, d);
            else if (k < 65) access(0, 1, ch, 0, d);
            else if (k < 90) access(1, 0, ch, 0, d);
            else if (k < 96) access(1, 1, ch, 1'($urandom), d);
            else             access(0, 0, ch, 0, d);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule